// File: doc/BRIEF.md
# Triggered Bus Trace Buffer

This block keeps a running history of a processor's buses. Once armed, it writes one frame per clock cycle into a circular memory. A frame holds the address bus, the data bus, the control lines and a 32-bit time-tag. When a programmable trigger fires, capture goes on for a chosen number of further frames and then freezes. The stored window therefore covers the cycles leading up to the event as well as the cycles just after it.

The trigger is built from four match terms: address, data, control lines and serial-port event strobes. Each term has a compare value and a care mask, and it can be inverted. The enabled terms are then combined either all-of or any-of. A host walks the frozen history through an index port, where index 0 is the oldest frame. The memory depth is set by `DEPTH_W`; setting `DEPTH_W = 13` gives 8192 frames.

Top module: `tbt_trace_buffer`

## Requirements
- R1: After reset, `done` is 0, `frame_count` is 0 and every read returns all-zero fields.
- R2: While capturing, every clock cycle stores one frame holding `bus_addr`, `bus_data` and `bus_ctrl` as sampled at that edge.
- R3: The time-tag is a free-running 32-bit cycle counter. Frames stored on consecutive cycles carry tags that differ by exactly 1.
- R4: A match term is true when every bit set in its care mask has the same value in the sampled bus and in the compare value. Bits whose care bit is clear are ignored.
- R5: Setting a term's `term_inv` bit inverts that term's result. The bit order is 0 = address, 1 = data, 2 = control, 3 = serial.
- R6: With `comb_any` = 0, the trigger fires when all enabled terms are true. With `comb_any` = 1, it fires when any enabled term is true. With no term enabled, it never fires.
- R7: After the trigger frame, exactly `post_count` more frames are stored. Then `done` rises and the write pointer, the frame count and the memory stay frozen.
- R8: Trigger conditions are ignored unless the buffer has been armed. Without an arm, nothing is stored and `done` stays 0.
- R9: An `arm` pulse clears `done` and `frame_count` and restarts capture on the next cycle. `frame_count` saturates at 2^`DEPTH_W`.
- R10: Read index i returns the i-th oldest stored frame, one cycle after the index is presented. After a wrap, index 0 is the oldest frame that survived.
- R11: A read index greater than or equal to `frame_count` returns zeros in all fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start a new capture, clearing the previous one |
| bus_addr | input | ADDR_W | Observed address bus |
| bus_data | input | DATA_W | Observed data bus |
| bus_ctrl | input | 8 | Observed control lines |
| bus_ser | input | 2 | Serial-port event strobes |
| addr_val | input | ADDR_W | Address compare value |
| addr_care | input | ADDR_W | Address care mask |
| data_val | input | DATA_W | Data compare value |
| data_care | input | DATA_W | Data care mask |
| ctrl_val | input | 8 | Control compare value |
| ctrl_care | input | 8 | Control care mask |
| ser_val | input | 2 | Serial compare value |
| ser_care | input | 2 | Serial care mask |
| term_en | input | 4 | Per-term enable |
| term_inv | input | 4 | Per-term inversion |
| comb_any | input | 1 | 0 = all-of combine, 1 = any-of combine |
| post_count | input | DEPTH_W+1 | Frames stored after the trigger frame |
| done | output | 1 | Capture finished and frozen |
| frame_count | output | DEPTH_W+1 | Number of valid frames |
| rd_idx | input | DEPTH_W+1 | Readback index, 0 = oldest |
| rd_addr | output | ADDR_W | Read frame: address |
| rd_data | output | DATA_W | Read frame: data |
| rd_ctrl | output | 8 | Read frame: control lines |
| rd_tag | output | 32 | Read frame: time-tag |

## Verification
The bus is driven with a ramp in which the address equals the step number, the data is three times the step, control bit 7 follows step bit 3, and a serial strobe appears on step 6. Under this ramp, each trigger setup fires on a known step. A table of setups exercises:
- single terms;
- partial care masks;
- inverted terms;
- all-of against any-of combining;
- an unsatisfiable all-of;
- an empty enable set.

Because each setup fires on a different step, a wrong mask, inversion or combine rule shows up as a wrong frame count and a wrong trigger frame. Directed runs then cover:
- wrap-around with saturation;
- a zero post count;
- capture without an arm;
- re-arming;
- out-of-range reads.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    localparam int TAG_W     = 32;
    localparam int CTRL_W    = 8;
    localparam int SER_W     = 2;
    localparam int NUM_TERMS = 4;

    localparam int TERM_ADDR = 0;
    localparam int TERM_DATA = 1;
    localparam int TERM_CTRL = 2;
    localparam int TERM_SER  = 3;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_PRE  = 2'd1,
        CAP_POST = 2'd2,
        CAP_DONE = 2'd3
    } cap_state_t;

    typedef enum logic {
        COMB_ALL = 1'b0,
        COMB_ANY = 1'b1
    } comb_mode_t;

endpackage

// File: rtl/tbt_match_term.sv
module tbt_match_term #(
    parameter int W = 8
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] value,
    input  logic [W-1:0] care,
    input  logic         invert,
    output logic         hit
);
    logic equal;

    // Only the bits selected by the care mask take part in the compare.
    assign equal = (((sample ^ value) & care) == '0);
    assign hit   = equal ^ invert;

endmodule

// File: rtl/tbt_trig_combine.sv
module tbt_trig_combine
    import tbt_pkg::*;
#(
    parameter int N = NUM_TERMS
) (
    input  logic [N-1:0] hits,
    input  logic [N-1:0] enables,
    input  comb_mode_t   mode,
    output logic         fire
);
    logic any_enabled;
    logic all_true;
    logic some_true;

    assign any_enabled = |enables;
    assign all_true    = &(hits | ~enables);   // disabled terms do not block
    assign some_true   = |(hits & enables);    // disabled terms do not count
    assign fire        = any_enabled && ((mode == COMB_ANY) ? some_true : all_true);

endmodule

// File: rtl/tbt_capture_ctrl.sv
module tbt_capture_ctrl
    import tbt_pkg::*;
#(
    parameter int DEPTH_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm,
    input  logic               fire,
    input  logic [DEPTH_W:0]   post_count,
    output logic               we,
    output logic [DEPTH_W-1:0] wptr,
    output logic [DEPTH_W:0]   count,
    output logic               done
);
    localparam int              DEPTH = 1 << DEPTH_W;
    localparam int              CNT_W = DEPTH_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    cap_state_t       state;
    logic [CNT_W-1:0] post_left;
    logic             capturing;

    assign capturing = (state == CAP_PRE) || (state == CAP_POST);
    assign we        = capturing && !arm;
    assign done      = (state == CAP_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CAP_IDLE;
            wptr      <= '0;
            count     <= '0;
            post_left <= '0;
        end else if (arm) begin
            state     <= CAP_PRE;
            wptr      <= '0;
            count     <= '0;
            post_left <= '0;
        end else if (capturing) begin
            wptr <= wptr + 1'b1;
            if (count != FULL) begin
                count <= count + 1'b1;
            end
            unique case (state)
                CAP_PRE: begin
                    if (fire) begin
                        if (post_count == '0) begin
                            state <= CAP_DONE;
                        end else begin
                            state     <= CAP_POST;
                            post_left <= post_count;
                        end
                    end
                end
                CAP_POST: begin
                    post_left <= post_left - 1'b1;
                    if (post_left == CNT_W'(1)) begin
                        state <= CAP_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        count <= FULL);

    assert_arm_clears_R9: assert property (@(posedge clk) disable iff (rst)
        arm |=> (count == '0) && !done);

    assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !arm) |=> ($stable(wptr) && $stable(count) && done));

    assert_post_live_R7: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_POST) |-> (post_left != '0));

    assert_unarmed_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_IDLE && !arm) |=> (state == CAP_IDLE) && (count == '0));

endmodule

// File: rtl/tbt_frame_ram.sv
module tbt_frame_ram #(
    parameter int AW = 10,
    parameter int W  = 78
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/tbt_trace_buffer.sv
module tbt_trace_buffer
    import tbt_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 24,
    parameter int DEPTH_W = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 arm,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_data,
    input  logic [CTRL_W-1:0]    bus_ctrl,
    input  logic [SER_W-1:0]     bus_ser,
    input  logic [ADDR_W-1:0]    addr_val,
    input  logic [ADDR_W-1:0]    addr_care,
    input  logic [DATA_W-1:0]    data_val,
    input  logic [DATA_W-1:0]    data_care,
    input  logic [CTRL_W-1:0]    ctrl_val,
    input  logic [CTRL_W-1:0]    ctrl_care,
    input  logic [SER_W-1:0]     ser_val,
    input  logic [SER_W-1:0]     ser_care,
    input  logic [NUM_TERMS-1:0] term_en,
    input  logic [NUM_TERMS-1:0] term_inv,
    input  logic                 comb_any,
    input  logic [DEPTH_W:0]     post_count,
    output logic                 done,
    output logic [DEPTH_W:0]     frame_count,
    input  logic [DEPTH_W:0]     rd_idx,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [CTRL_W-1:0]    rd_ctrl,
    output logic [TAG_W-1:0]     rd_tag
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [CTRL_W-1:0] ctrl;
        logic [TAG_W-1:0]  tag;
    } frame_t;

    localparam int FRAME_W = $bits(frame_t);

    logic [TAG_W-1:0]     tag_ctr;
    logic [NUM_TERMS-1:0] hits;
    logic                 fire;
    logic                 we;
    logic [DEPTH_W-1:0]   wptr;
    logic [DEPTH_W-1:0]   rd_phys;
    logic                 rd_in_range;
    logic                 rd_valid_q;
    frame_t               wr_frame;
    frame_t               ram_q;
    frame_t               rd_frame;

    // Free-running time-tag.
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_ctr <= '0;
        end else begin
            tag_ctr <= tag_ctr + 32'd1;
        end
    end

    // Match terms: address, data, control lines, serial-port events.
    tbt_match_term #(.W(ADDR_W)) u_term_addr (
        .sample(bus_addr), .value(addr_val), .care(addr_care),
        .invert(term_inv[TERM_ADDR]), .hit(hits[TERM_ADDR]));

    tbt_match_term #(.W(DATA_W)) u_term_data (
        .sample(bus_data), .value(data_val), .care(data_care),
        .invert(term_inv[TERM_DATA]), .hit(hits[TERM_DATA]));

    tbt_match_term #(.W(CTRL_W)) u_term_ctrl (
        .sample(bus_ctrl), .value(ctrl_val), .care(ctrl_care),
        .invert(term_inv[TERM_CTRL]), .hit(hits[TERM_CTRL]));

    tbt_match_term #(.W(SER_W)) u_term_ser (
        .sample(bus_ser), .value(ser_val), .care(ser_care),
        .invert(term_inv[TERM_SER]), .hit(hits[TERM_SER]));

    tbt_trig_combine #(.N(NUM_TERMS)) u_combine (
        .hits(hits), .enables(term_en),
        .mode(comb_mode_t'(comb_any)), .fire(fire));

    tbt_capture_ctrl #(.DEPTH_W(DEPTH_W)) u_ctrl (
        .clk(clk), .rst(rst), .arm(arm), .fire(fire),
        .post_count(post_count), .we(we), .wptr(wptr),
        .count(frame_count), .done(done));

    assign wr_frame = '{addr: bus_addr, data: bus_data, ctrl: bus_ctrl, tag: tag_ctr};

    // Oldest frame sits frame_count slots behind the write pointer.
    assign rd_phys     = wptr - frame_count[DEPTH_W-1:0] + rd_idx[DEPTH_W-1:0];
    assign rd_in_range = (rd_idx < frame_count);

    tbt_frame_ram #(.AW(DEPTH_W), .W(FRAME_W)) u_ram (
        .clk(clk), .we(we), .waddr(wptr), .wdata(wr_frame),
        .raddr(rd_phys), .rdata(ram_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_in_range;
        end
    end

    assign rd_frame = rd_valid_q ? ram_q : '0;
    assign rd_addr  = rd_frame.addr;
    assign rd_data  = rd_frame.data;
    assign rd_ctrl  = rd_frame.ctrl;
    assign rd_tag   = rd_frame.tag;

    assert_tag_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(tag_ctr) |=> tag_ctr == $past(tag_ctr) + 32'd1);

    assert_oor_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_idx >= frame_count) |=> (rd_tag == '0) && (rd_addr == '0) &&
                                    (rd_data == '0) && (rd_ctrl == '0));

    assert_no_write_done_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !we || arm);

endmodule

// File: tb/tbt_trace_buffer_tb.sv
module tbt_trace_buffer_tb_top;

    localparam int ADDR_W  = 14;
    localparam int DATA_W  = 24;
    localparam int DEPTH_W = 4;
    localparam int NVEC    = 9;

    typedef struct packed {
        logic [3:0]        en;
        logic [3:0]        inv;
        logic              any;
        logic [13:0]       av;
        logic [13:0]       ac;
        logic [23:0]       dv;
        logic [23:0]       dc;
        logic [7:0]        cv;
        logic [7:0]        cc;
        logic [1:0]        sv;
        logic [1:0]        sc;
        logic signed [7:0] k;   // expected trigger step, -1 = never
    } vec_t;

    // Ramp: addr=i, data=3*i, ctrl[7]=i[3], serial strobe 2'b10 at i=6.
    localparam vec_t VECS [NVEC] = '{
        '{4'b0001, 4'b0000, 1'b0, 14'd5, 14'h3fff, 24'd0,  24'd0,      8'h00, 8'h00, 2'd0, 2'd0, 8'sd5},
        '{4'b0010, 4'b0000, 1'b0, 14'd0, 14'd0,    24'd21, 24'hffffff, 8'h00, 8'h00, 2'd0, 2'd0, 8'sd7},
        '{4'b0101, 4'b0000, 1'b0, 14'd1, 14'd1,    24'd0,  24'd0,      8'h80, 8'h80, 2'd0, 2'd0, 8'sd9},
        '{4'b0101, 4'b0000, 1'b1, 14'd3, 14'h3fff, 24'd0,  24'd0,      8'h80, 8'h80, 2'd0, 2'd0, 8'sd3},
        '{4'b0001, 4'b0001, 1'b0, 14'd0, 14'h3fff, 24'd0,  24'd0,      8'h00, 8'h00, 2'd0, 2'd0, 8'sd1},
        '{4'b0101, 4'b0100, 1'b0, 14'd0, 14'd3,    24'd0,  24'd0,      8'h00, 8'h80, 2'd0, 2'd0, 8'sd8},
        '{4'b0000, 4'b0000, 1'b0, 14'd0, 14'd0,    24'd0,  24'd0,      8'h00, 8'h00, 2'd0, 2'd0, -8'sd1},
        '{4'b1000, 4'b0000, 1'b0, 14'd0, 14'd0,    24'd0,  24'd0,      8'h00, 8'h00, 2'd2, 2'd2, 8'sd6},
        '{4'b0101, 4'b0000, 1'b0, 14'd2, 14'h3fff, 24'd0,  24'd0,      8'h80, 8'h80, 2'd0, 2'd0, -8'sd1}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              arm = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_data = '0;
    logic [7:0]        bus_ctrl = '0;
    logic [1:0]        bus_ser = '0;
    logic [ADDR_W-1:0] addr_val = '0, addr_care = '0;
    logic [DATA_W-1:0] data_val = '0, data_care = '0;
    logic [7:0]        ctrl_val = '0, ctrl_care = '0;
    logic [1:0]        ser_val = '0, ser_care = '0;
    logic [3:0]        term_en = '0, term_inv = '0;
    logic              comb_any = 1'b0;
    logic [DEPTH_W:0]  post_count = '0;
    logic              done;
    logic [DEPTH_W:0]  frame_count;
    logic [DEPTH_W:0]  rd_idx = '0;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [7:0]        rd_ctrl;
    logic [31:0]       rd_tag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tbt_trace_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH_W(DEPTH_W)) dut_i (
        .clk(clk), .rst(rst), .arm(arm),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl), .bus_ser(bus_ser),
        .addr_val(addr_val), .addr_care(addr_care), .data_val(data_val), .data_care(data_care),
        .ctrl_val(ctrl_val), .ctrl_care(ctrl_care), .ser_val(ser_val), .ser_care(ser_care),
        .term_en(term_en), .term_inv(term_inv), .comb_any(comb_any), .post_count(post_count),
        .done(done), .frame_count(frame_count), .rd_idx(rd_idx),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_ctrl(rd_ctrl), .rd_tag(rd_tag));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_step(input int i);
        bus_addr = ADDR_W'(i);
        bus_data = DATA_W'(3 * i);
        bus_ctrl = {4'(i), ~4'(i)};
        bus_ser  = (i == 6) ? 2'b10 : 2'b00;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_arm();
        arm = 1'b1;
        @(posedge clk);
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic read_frame(input int idx);
        rd_idx = (DEPTH_W + 1)'(idx);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_vec(input vec_t v);
        term_en = v.en; term_inv = v.inv; comb_any = v.any;
        addr_val = v.av; addr_care = v.ac;
        data_val = v.dv; data_care = v.dc;
        ctrl_val = v.cv; ctrl_care = v.cc;
        ser_val = v.sv; ser_care = v.sc;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] tag0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 done", 64'(done), 64'd0);
        check("R1 count", 64'(frame_count), 64'd0);
        read_frame(0);
        check("R1 read zero", 64'(rd_tag) | 64'(rd_addr), 64'd0);

        // R8: trigger setup matches but buffer not armed
        addr_val = 14'd3; addr_care = 14'h3fff; term_en = 4'b0001; post_count = 5'd1;
        for (int i = 0; i < 6; i++) drive_step(i);
        check("R8 not armed done", 64'(done), 64'd0);
        check("R8 not armed count", 64'(frame_count), 64'd0);

        // Table: trigger terms and combine modes (R4 R5 R6 R7 R2)
        post_count = 5'd2;
        for (int v = 0; v < NVEC; v++) begin
            load_vec(VECS[v]);
            do_arm();
            for (int i = 0; i < 12; i++) drive_step(i);
            if (VECS[v].k < 0) begin
                check($sformatf("R6 vec%0d no trigger", v), 64'(done), 64'd0);
                check($sformatf("R6 vec%0d count", v), 64'(frame_count), 64'd12);
            end else begin
                check($sformatf("R4 R5 R6 vec%0d done", v), 64'(done), 64'd1);
                check($sformatf("R7 vec%0d count", v), 64'(frame_count), 64'(VECS[v].k + 3));
                read_frame(int'(VECS[v].k));
                check($sformatf("R2 vec%0d trig addr", v), 64'(rd_addr), 64'(VECS[v].k));
                check($sformatf("R2 vec%0d trig data", v), 64'(rd_data), 64'(3 * VECS[v].k));
                check($sformatf("R2 vec%0d trig ctrl", v), 64'(rd_ctrl),
                      64'({4'(VECS[v].k), ~4'(VECS[v].k)}));
            end
        end

        // R10 R9: wrap-around and saturation
        load_vec(VECS[0]);
        addr_val = 14'd20; post_count = 5'd3;
        do_arm();
        check("R9 arm clears done", 64'(done), 64'd0);
        check("R9 arm clears count", 64'(frame_count), 64'd0);
        for (int i = 0; i < 30; i++) drive_step(i);
        check("R7 wrap done", 64'(done), 64'd1);
        check("R9 saturate", 64'(frame_count), 64'd16);
        read_frame(0);
        check("R10 oldest after wrap", 64'(rd_addr), 64'd8);
        tag0 = rd_tag;
        read_frame(1);
        check("R3 tag step", 64'(rd_tag - tag0), 64'd1);
        read_frame(15);
        check("R10 newest", 64'(rd_addr), 64'd23);
        read_frame(16);
        check("R11 beyond count", 64'(rd_addr) | 64'(rd_tag) | 64'(rd_data), 64'd0);

        // R8 R7: after done, matching bus stays ignored and memory frozen
        for (int i = 0; i < 25; i++) drive_step(20);
        check("R8 after done count", 64'(frame_count), 64'd16);
        read_frame(15);
        check("R7 frozen newest", 64'(rd_addr), 64'd23);

        // R7: zero post count, trigger frame is last
        addr_val = 14'd4; post_count = '0;
        do_arm();
        for (int i = 0; i < 10; i++) drive_step(i);
        check("R7 zero post count", 64'(frame_count), 64'd5);
        read_frame(4);
        check("R7 zero post last frame", 64'(rd_addr), 64'd4);
        read_frame(0);
        check("R10 first frame", 64'(rd_addr), 64'd0);
        read_frame(5);
        check("R11 index equals count", 64'(rd_addr) | 64'(rd_tag), 64'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule